// File: doc/BRIEF.md
# Dual-Channel Double-Data-Rate Sample Deinterleaver

This block sits on the receive side of a two-channel converter link. The link time-shares one parallel bus between the channels. The converter forwards its clock with the data, and the phase of that clock tells the two channels apart. While the forwarded clock is low the bus carries the channel A word. While it is high the bus carries the channel B word. Each word comes with an over-range bit, refreshed once per sample. That bit goes high when the offset-binary code has reached positive full scale. While it is high the code stays at all ones and never wraps.

The block registers the A word on the rising edge and the B word on the falling edge. On the next rising edge it presents both as one aligned pair. The outputs are the two words, the over-range bit of each word and a pair-valid strobe. The block also keeps a sticky over-range record per channel, which only a dedicated clear input resets. A debug check flags any word whose over-range bit is set while its code is not at full scale.

Top module: `ddr_pair_rx`

## Requirements
- R1: While `rst_n` is low, `a_word`, `b_word`, `a_ovr`, `b_ovr`, `a_ovr_sticky`, `b_ovr_sticky`, `pair_valid` and `code_err` are all 0.
- R2: The word on `ddr_data` at a rising edge of `clk` (the end of the low phase) appears on `a_word` from the following rising edge onward, for one clock period.
- R3: The word on `ddr_data` at the falling edge between those two rising edges appears on `b_word` in the same clock period as the A word of R2.
- R4: `pair_valid` is 0 after the first rising edge following reset release. It is 1 after every later rising edge, each time marking a freshly transferred complete pair.
- R5: `a_ovr` and `b_ovr` carry the `ddr_ovr` bit captured with the presented A and B word. A full-scale code (all ones) passes through unchanged.
- R6: `a_ovr_sticky` is set by a valid pair whose A over-range bit is 1, and `b_ovr_sticky` likewise for B. A flag never sets from the other channel's bit and stays set until cleared.
- R7: `ovr_clear` high at a rising edge clears both sticky flags at that edge. If the pair presented at the same edge carries an over-range bit, that channel's flag is set instead (set wins).
- R8: `code_err` is 1 exactly while a presented word has its over-range bit at 1 and a code other than all ones. A full-scale code or a cleared over-range bit gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Forwarded converter clock; low phase carries A, high phase carries B |
| rst_n | input | 1 | Asynchronous active-low reset |
| ddr_data | input | DATA_W | Shared double-data-rate sample bus |
| ddr_ovr | input | 1 | Over-range bit accompanying the current word |
| ovr_clear | input | 1 | Clears both sticky over-range flags at a rising edge |
| a_word | output | DATA_W | Channel A code of the presented pair |
| b_word | output | DATA_W | Channel B code of the presented pair |
| a_ovr | output | 1 | Over-range bit of the presented A word |
| b_ovr | output | 1 | Over-range bit of the presented B word |
| a_ovr_sticky | output | 1 | Sticky over-range record for channel A |
| b_ovr_sticky | output | 1 | Sticky over-range record for channel B |
| pair_valid | output | 1 | Presented pair is complete and fresh |
| code_err | output | 1 | Over-range bit seen on a code that is not full scale |

## Verification
The bench builds the block with a 4-bit sample width instead of the default 10. This makes all 256 combinations of A and B codes a short sweep. Full scale is the code 15, so every pair in which either word reaches full scale is exercised. With the small width the bench can also try each placement of the over-range bit: on full-scale codes, on codes below full scale and on one channel only. In the same run it covers clears that coincide with a fresh over-range pair.

// File: rtl/ddr_rx_pkg.sv
`timescale 1ns/1ps
package ddr_rx_pkg;
    localparam int NUM_CH = 2;
    typedef enum logic {CH_A = 1'b0, CH_B = 1'b1} ch_e;
endpackage

// File: rtl/ddr_phase_capture.sv
`timescale 1ns/1ps
module ddr_phase_capture #(
    parameter int DATA_W = 10,
    localparam int WORD_W = DATA_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] ddr_data,
    input  logic              ddr_ovr,
    output logic [WORD_W-1:0] a_cap,
    output logic [WORD_W-1:0] b_cap,
    output logic              b_full
);
    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              seen;
    } half_t;

    half_t rise_d, rise_q;
    half_t fall_d, fall_q;

    always_comb begin
        rise_d.word = {ddr_ovr, ddr_data};
        rise_d.seen = 1'b1;
        fall_d.word = {ddr_ovr, ddr_data};
        fall_d.seen = rise_q.seen;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rise_q <= '0;
        else        rise_q <= rise_d;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) fall_q <= '0;
        else        fall_q <= fall_d;
    end

    assign a_cap  = rise_q.word;
    assign b_cap  = fall_q.word;
    assign b_full = fall_q.seen;
endmodule

// File: rtl/ovr_sticky.sv
`timescale 1ns/1ps
module ovr_sticky #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         set_en,
    input  logic [N-1:0] flags,
    output logic [N-1:0] sticky
);
    logic [N-1:0] sticky_d, sticky_q;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            sticky_d[i] = (clear ? 1'b0 : sticky_q[i]) | (set_en & flags[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sticky_q <= '0;
        else        sticky_q <= sticky_d;
    end

    assign sticky = sticky_q;
endmodule

// File: rtl/ddr_pair_rx.sv
`timescale 1ns/1ps
module ddr_pair_rx #(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] ddr_data,
    input  logic              ddr_ovr,
    input  logic              ovr_clear,
    output logic [DATA_W-1:0] a_word,
    output logic [DATA_W-1:0] b_word,
    output logic              a_ovr,
    output logic              b_ovr,
    output logic              a_ovr_sticky,
    output logic              b_ovr_sticky,
    output logic              pair_valid,
    output logic              code_err
);
    import ddr_rx_pkg::*;
    localparam int WORD_W = DATA_W + 1;

    logic [WORD_W-1:0] a_cap, b_cap, cap [NUM_CH];
    logic              b_full;
    logic [NUM_CH-1:0] ch_ovr, ch_bad, sticky;

    ddr_phase_capture #(.DATA_W(DATA_W)) u_capture (
        .clk(clk), .rst_n(rst_n), .ddr_data(ddr_data), .ddr_ovr(ddr_ovr),
        .a_cap(a_cap), .b_cap(b_cap), .b_full(b_full)
    );

    assign cap[CH_A] = a_cap;
    assign cap[CH_B] = b_cap;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        assign ch_ovr[c] = cap[c][WORD_W-1];
        assign ch_bad[c] = ch_ovr[c] & ~(&cap[c][DATA_W-1:0]);
    end

    ovr_sticky #(.N(NUM_CH)) u_sticky (
        .clk(clk), .rst_n(rst_n), .clear(ovr_clear), .set_en(b_full),
        .flags(ch_ovr), .sticky(sticky)
    );

    typedef struct packed {
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
        logic              a_or;
        logic              b_or;
        logic              valid;
        logic              err;
    } pair_t;

    pair_t pair_d, pair_q;

    always_comb begin
        pair_d.a     = a_cap[DATA_W-1:0];
        pair_d.b     = b_cap[DATA_W-1:0];
        pair_d.a_or  = ch_ovr[CH_A];
        pair_d.b_or  = ch_ovr[CH_B];
        pair_d.valid = b_full;
        pair_d.err   = |ch_bad;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pair_q <= '0;
        else        pair_q <= pair_d;
    end

    assign a_word       = pair_q.a;
    assign b_word       = pair_q.b;
    assign a_ovr        = pair_q.a_or;
    assign b_ovr        = pair_q.b_or;
    assign pair_valid   = pair_q.valid;
    assign code_err     = pair_q.err;
    assign a_ovr_sticky = sticky[CH_A];
    assign b_ovr_sticky = sticky[CH_B];
endmodule

// File: rtl/ddr_pair_rx_chk.sv
`timescale 1ns/1ps
module ddr_pair_rx_chk #(
    parameter int DATA_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] ddr_data,
    input logic              ddr_ovr,
    input logic              ovr_clear,
    input logic [DATA_W-1:0] a_word,
    input logic [DATA_W-1:0] b_word,
    input logic              a_ovr,
    input logic              b_ovr,
    input logic              a_ovr_sticky,
    input logic              b_ovr_sticky,
    input logic              pair_valid,
    input logic              code_err
);
    p_valid_stays_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |=> pair_valid);

    p_a_sticky_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(a_ovr_sticky) |-> a_ovr);

    p_b_sticky_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(b_ovr_sticky) |-> b_ovr);

    p_a_sticky_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (a_ovr_sticky && !ovr_clear) |=> a_ovr_sticky);

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_clear |=> ((!a_ovr_sticky || a_ovr) && (!b_ovr_sticky || b_ovr)));

    p_err_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        code_err |-> ((a_ovr && a_word != '1) || (b_ovr && b_word != '1)));
endmodule

bind ddr_pair_rx ddr_pair_rx_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_ddr_pair_rx.sv
`timescale 1ns/1ps
module tb_ddr_pair_rx;
    localparam int BW   = 4;
    localparam int MAXC = (1 << BW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [BW-1:0] ddr_data = '0;
    logic          ddr_ovr = 1'b0;
    logic          ovr_clear = 1'b0;
    logic [BW-1:0] a_word, b_word;
    logic          a_ovr, b_ovr, a_ovr_sticky, b_ovr_sticky, pair_valid, code_err;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [BW-1:0] pa, pb;
    logic          pa_o, pb_o, prev_have;
    logic [1:0]    exp_sticky;

    always #2 clk = ~clk;

    ddr_pair_rx #(.DATA_W(BW)) dut (
        .clk(clk), .rst_n(rst_n), .ddr_data(ddr_data), .ddr_ovr(ddr_ovr),
        .ovr_clear(ovr_clear), .a_word(a_word), .b_word(b_word),
        .a_ovr(a_ovr), .b_ovr(b_ovr), .a_ovr_sticky(a_ovr_sticky),
        .b_ovr_sticky(b_ovr_sticky), .pair_valid(pair_valid), .code_err(code_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int a, input bit oa, input int b, input bit ob, input bit clr);
        bit exp_err;
        @(negedge clk); #0.5;
        ddr_data = a[BW-1:0]; ddr_ovr = oa; ovr_clear = clr;
        @(posedge clk); #0.5;
        if (clr) exp_sticky = 2'b00;
        if (prev_have) exp_sticky = exp_sticky | {pb_o, pa_o};
        chk("R4 pair_valid", int'(pair_valid), int'(prev_have));
        if (prev_have) begin
            exp_err = (pa_o && pa != MAXC) || (pb_o && pb != MAXC);
            chk("R2 a_word", int'(a_word), int'(pa));
            chk("R3 b_word", int'(b_word), int'(pb));
            chk("R5 a_ovr", int'(a_ovr), int'(pa_o));
            chk("R5 b_ovr", int'(b_ovr), int'(pb_o));
            chk("R8 code_err", int'(code_err), int'(exp_err));
        end
        chk(clr ? "R7 a_sticky" : "R6 a_sticky", int'(a_ovr_sticky), int'(exp_sticky[0]));
        chk(clr ? "R7 b_sticky" : "R6 b_sticky", int'(b_ovr_sticky), int'(exp_sticky[1]));
        ddr_data = b[BW-1:0]; ddr_ovr = ob;
        pa = a[BW-1:0]; pa_o = oa; pb = b[BW-1:0]; pb_o = ob; prev_have = 1'b1;
    endtask

    initial begin
        prev_have = 1'b0; exp_sticky = 2'b00;
        pa = '0; pb = '0; pa_o = 1'b0; pb_o = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R1: everything quiet under reset
        chk("R1 a_word", int'(a_word), 0);
        chk("R1 b_word", int'(b_word), 0);
        chk("R1 ovr", int'({a_ovr, b_ovr}), 0);
        chk("R1 sticky", int'({a_ovr_sticky, b_ovr_sticky}), 0);
        chk("R1 pair_valid", int'(pair_valid), 0);
        chk("R1 code_err", int'(code_err), 0);
        rst_n = 1'b1;

        // Exhaustive A/B code sweep, over-range only on full scale
        for (int i = 0; i < (1 << (2 * BW)); i++) begin
            int a = i >> BW;
            int b = i & MAXC;
            step(a, a == MAXC, b, b == MAXC, 1'b0);
        end
        // R7: clear with a clean pair
        step(3, 0, 4, 0, 0);
        step(1, 0, 2, 0, 1);
        // R6 and R7: set wins against clear, channel isolation
        step(MAXC, 1, 2, 0, 0);
        step(0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0);
        // R8: over-range bit on codes below full scale
        step(5, 1, MAXC, 0, 1);
        step(0, 0, 7, 1, 0);
        step(MAXC, 0, MAXC, 1, 0);
        step(0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule